// File: doc/BRIEF.md
# Single-Note Three-Product Vending Controller

This block is the control core of a small dispenser that is paid with one note of a fixed value (10 units). It keeps the credit as a count of held notes, from zero up to a cap of three notes (30 units). It accepts five request lines: note inserted, water select, snack select, drink select and cancel. At most one of them is high in any clock cycle. Water and snacks each cost two notes and the drink costs three.

When a request is accepted, the matching release line pulses for exactly one cycle, on the cycle after the request. The credit register changes on that same edge. A cheaper purchase keeps any leftover credit. A note that would push the credit past the cap is handed back on its own pulse. Cancel refunds the whole balance.

The credit can be stored as a 2-bit binary count (the minimised default) or as a one-hot vector; a parameter selects which. Reset is asynchronous and active high.

Top module: `vend_ctrl`

## Requirements
- R1: An active-high asynchronous reset clears the credit to zero and drives every release output low, without waiting for a clock edge.
- R2: A note arriving while the credit is below three notes raises the credit by one note on the next edge and pulses no output.
- R3: A note arriving while the credit is at three notes pulses reject_out on the next cycle, and the credit stays at three notes.
- R4: A water select with a credit of at least two notes pulses water_out on the next cycle and lowers the credit by two notes.
- R5: A snack select with a credit of at least two notes pulses snack_out on the next cycle and lowers the credit by two notes.
- R6: A drink select with a credit of three notes pulses drink_out on the next cycle and returns the credit to zero.
- R7: A select whose price exceeds the credit has no effect: no output pulses and the credit is unchanged.
- R8: Cancel with a nonzero credit pulses refund_out on the next cycle and clears the credit. Cancel at zero credit pulses nothing.
- R9: A cycle with no request active holds the credit, and all outputs are low on the following cycle.
- R10: At most one release output is high in any cycle, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| note_in | input | 1 | A note has been inserted |
| sel_water | input | 1 | Water request |
| sel_snack | input | 1 | Snack request |
| sel_drink | input | 1 | Drink request |
| cancel_in | input | 1 | Cancel, refund the balance |
| water_out | output | 1 | Water release pulse |
| snack_out | output | 1 | Snack release pulse |
| drink_out | output | 1 | Drink release pulse |
| refund_out | output | 1 | Full refund pulse |
| reject_out | output | 1 | Excess note return pulse |
| credit_q | output | CRED_W (2) | Held credit in notes |

## Verification
The bench builds two instances with the default prices (two, two and three notes) and a cap of three notes. One stores the credit in binary and the other one-hot. Both are driven in lockstep and checked against the same arithmetic model. With only four credit levels and six request kinds, the bench sweeps every pairing of starting credit and request. This covers every under-price select, the reject at the cap, and cancel at zero. It also follows each accepted pulse with an idle cycle and asserts reset in the middle of a cycle.

// File: rtl/vend_pkg.sv
package vend_pkg;

   typedef enum logic [2:0] {
      ACT_IDLE,
      ACT_NOTE,
      ACT_WATER,
      ACT_SNACK,
      ACT_DRINK,
      ACT_CANCEL
   } vend_act_e;

   typedef struct packed {
      logic water;
      logic snack;
      logic drink;
      logic refund;
      logic reject;
   } vend_pulse_t;

endpackage

// File: rtl/vend_req_decode.sv
module vend_req_decode
   import vend_pkg::*;
(
   input  logic      note_in,
   input  logic      sel_water,
   input  logic      sel_snack,
   input  logic      sel_drink,
   input  logic      cancel_in,
   output vend_act_e act
);
   // Requests are one-hot by contract; a fixed priority keeps a stray overlap deterministic.
   always_comb begin
      if (cancel_in)      act = ACT_CANCEL;
      else if (note_in)   act = ACT_NOTE;
      else if (sel_drink) act = ACT_DRINK;
      else if (sel_water) act = ACT_WATER;
      else if (sel_snack) act = ACT_SNACK;
      else                act = ACT_IDLE;
   end
endmodule

// File: rtl/vend_next_step.sv
module vend_next_step
   import vend_pkg::*;
#(
   parameter int unsigned MAX_NOTES   = 3,
   parameter int unsigned WATER_PRICE = 2,
   parameter int unsigned SNACK_PRICE = 2,
   parameter int unsigned DRINK_PRICE = 3,
   parameter int unsigned CRED_W      = 2
) (
   input  logic [CRED_W-1:0] credit,
   input  vend_act_e         act,
   output logic [CRED_W-1:0] credit_nxt,
   output vend_pulse_t       pulse_nxt
);
   localparam logic [CRED_W-1:0] CAP = CRED_W'(MAX_NOTES);
   localparam logic [CRED_W-1:0] PW  = CRED_W'(WATER_PRICE);
   localparam logic [CRED_W-1:0] PS  = CRED_W'(SNACK_PRICE);
   localparam logic [CRED_W-1:0] PD  = CRED_W'(DRINK_PRICE);

   always_comb begin
      credit_nxt = credit;
      pulse_nxt  = '0;
      case (act)
         ACT_NOTE: begin
            if (credit == CAP) pulse_nxt.reject = 1'b1;
            else               credit_nxt = credit + 1'b1;
         end
         ACT_WATER: begin
            if (credit >= PW) begin
               pulse_nxt.water = 1'b1;
               credit_nxt      = credit - PW;
            end
         end
         ACT_SNACK: begin
            if (credit >= PS) begin
               pulse_nxt.snack = 1'b1;
               credit_nxt      = credit - PS;
            end
         end
         ACT_DRINK: begin
            if (credit >= PD) begin
               pulse_nxt.drink = 1'b1;
               credit_nxt      = credit - PD;
            end
         end
         ACT_CANCEL: begin
            if (credit != '0) begin
               pulse_nxt.refund = 1'b1;
               credit_nxt       = '0;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/vend_credit_store.sv
module vend_credit_store #(
   parameter int unsigned MAX_NOTES = 3,
   parameter int unsigned CRED_W    = 2,
   parameter bit          ONE_HOT   = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CRED_W-1:0] d,
   output logic [CRED_W-1:0] q
);
   localparam int unsigned HOT_W = MAX_NOTES + 1;

   generate
      if (ONE_HOT) begin : g_hot
         logic [HOT_W-1:0] hot_q;
         logic [HOT_W-1:0] hot_d;

         always_comb begin
            for (int i = 0; i < HOT_W; i++) hot_d[i] = (d == CRED_W'(i));
         end

         always_ff @(posedge clk or posedge rst) begin
            if (rst) hot_q <= HOT_W'(1);
            else     hot_q <= hot_d;
         end

         always_comb begin
            q = '0;
            for (int i = 0; i < HOT_W; i++) begin
               if (hot_q[i]) q = CRED_W'(i);
            end
         end
      end else begin : g_bin
         logic [CRED_W-1:0] bin_q;

         always_ff @(posedge clk or posedge rst) begin
            if (rst) bin_q <= '0;
            else     bin_q <= d;
         end

         assign q = bin_q;
      end
   endgenerate
endmodule

// File: rtl/vend_pulse_reg.sv
module vend_pulse_reg
   import vend_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  vend_pulse_t d,
   output vend_pulse_t q
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst) q <= '0;
      else     q <= d;
   end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
   import vend_pkg::*;
#(
   parameter int unsigned MAX_NOTES   = 3,
   parameter int unsigned WATER_PRICE = 2,
   parameter int unsigned SNACK_PRICE = 2,
   parameter int unsigned DRINK_PRICE = 3,
   parameter bit          ONE_HOT     = 1'b0,
   localparam int unsigned CRED_W     = $clog2(MAX_NOTES + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              note_in,
   input  logic              sel_water,
   input  logic              sel_snack,
   input  logic              sel_drink,
   input  logic              cancel_in,
   output logic              water_out,
   output logic              snack_out,
   output logic              drink_out,
   output logic              refund_out,
   output logic              reject_out,
   output logic [CRED_W-1:0] credit_q
);
   if (MAX_NOTES < 1) begin : g_bad_cap
      $error("vend_ctrl: MAX_NOTES must be at least 1");
   end
   if (WATER_PRICE < 1 || WATER_PRICE > MAX_NOTES) begin : g_bad_water
      $error("vend_ctrl: WATER_PRICE out of range");
   end
   if (SNACK_PRICE < 1 || SNACK_PRICE > MAX_NOTES) begin : g_bad_snack
      $error("vend_ctrl: SNACK_PRICE out of range");
   end
   if (DRINK_PRICE < 1 || DRINK_PRICE > MAX_NOTES) begin : g_bad_drink
      $error("vend_ctrl: DRINK_PRICE out of range");
   end

   vend_act_e         act;
   logic [CRED_W-1:0] credit_nxt;
   vend_pulse_t       pulse_nxt;
   vend_pulse_t       pulse_q;

   vend_req_decode u_dec (
      .note_in   (note_in),
      .sel_water (sel_water),
      .sel_snack (sel_snack),
      .sel_drink (sel_drink),
      .cancel_in (cancel_in),
      .act       (act)
   );

   vend_next_step #(
      .MAX_NOTES   (MAX_NOTES),
      .WATER_PRICE (WATER_PRICE),
      .SNACK_PRICE (SNACK_PRICE),
      .DRINK_PRICE (DRINK_PRICE),
      .CRED_W      (CRED_W)
   ) u_step (
      .credit     (credit_q),
      .act        (act),
      .credit_nxt (credit_nxt),
      .pulse_nxt  (pulse_nxt)
   );

   vend_credit_store #(
      .MAX_NOTES (MAX_NOTES),
      .CRED_W    (CRED_W),
      .ONE_HOT   (ONE_HOT)
   ) u_store (
      .clk (clk),
      .rst (rst),
      .d   (credit_nxt),
      .q   (credit_q)
   );

   vend_pulse_reg u_pulse (
      .clk (clk),
      .rst (rst),
      .d   (pulse_nxt),
      .q   (pulse_q)
   );

   assign water_out  = pulse_q.water;
   assign snack_out  = pulse_q.snack;
   assign drink_out  = pulse_q.drink;
   assign refund_out = pulse_q.refund;
   assign reject_out = pulse_q.reject;
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
   parameter int unsigned MAX_NOTES   = 3,
   parameter int unsigned WATER_PRICE = 2,
   parameter int unsigned SNACK_PRICE = 2,
   parameter int unsigned DRINK_PRICE = 3,
   parameter int unsigned CRED_W      = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              note_in,
   input logic              sel_water,
   input logic              sel_snack,
   input logic              sel_drink,
   input logic              cancel_in,
   input logic              water_out,
   input logic              snack_out,
   input logic              drink_out,
   input logic              refund_out,
   input logic              reject_out,
   input logic [CRED_W-1:0] credit_q
);
   localparam logic [CRED_W-1:0] CAP = CRED_W'(MAX_NOTES);
   localparam logic [CRED_W-1:0] PW  = CRED_W'(WATER_PRICE);
   localparam logic [CRED_W-1:0] PD  = CRED_W'(DRINK_PRICE);

   logic [4:0] outs;
   logic       idle;
   assign outs = {water_out, snack_out, drink_out, refund_out, reject_out};
   assign idle = !(note_in || sel_water || sel_snack || sel_drink || cancel_in);

   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (credit_q == '0 && outs == '0));

   a_r2_note_step: assert property (@(posedge clk) disable iff (rst)
      (note_in && credit_q < CAP) |=> (credit_q == $past(credit_q) + 1'b1 && !reject_out));

   a_r3_cap_reject: assert property (@(posedge clk) disable iff (rst)
      (note_in && credit_q == CAP) |=> (reject_out && credit_q == CAP));

   a_r4_water_sale: assert property (@(posedge clk) disable iff (rst)
      (sel_water && credit_q >= PW) |=> (water_out && credit_q == $past(credit_q) - PW));

   a_r6_drink_sale: assert property (@(posedge clk) disable iff (rst)
      (sel_drink && credit_q >= PD) |=> (drink_out && credit_q == $past(credit_q) - PD));

   a_r7_short_water: assert property (@(posedge clk) disable iff (rst)
      (sel_water && credit_q < PW) |=> (!water_out && $stable(credit_q)));

   a_r8_refund: assert property (@(posedge clk) disable iff (rst)
      (cancel_in && credit_q != '0) |=> (refund_out && credit_q == '0));

   a_r8_no_empty_refund: assert property (@(posedge clk) disable iff (rst)
      (cancel_in && credit_q == '0) |=> !refund_out);

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
      idle |=> (outs == '0 && $stable(credit_q)));

   a_r10_single_out: assert property (@(posedge clk) disable iff (rst)
      $onehot0(outs));
endmodule

bind vend_ctrl vend_ctrl_chk #(
   .MAX_NOTES   (MAX_NOTES),
   .WATER_PRICE (WATER_PRICE),
   .SNACK_PRICE (SNACK_PRICE),
   .DRINK_PRICE (DRINK_PRICE),
   .CRED_W      (CRED_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .note_in    (note_in),
   .sel_water  (sel_water),
   .sel_snack  (sel_snack),
   .sel_drink  (sel_drink),
   .cancel_in  (cancel_in),
   .water_out  (water_out),
   .snack_out  (snack_out),
   .drink_out  (drink_out),
   .refund_out (refund_out),
   .reject_out (reject_out),
   .credit_q   (credit_q)
);

// File: tb/vend_ctrl_tb_top.sv
module vend_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic note_in = 1'b0, sel_water = 1'b0, sel_snack = 1'b0, sel_drink = 1'b0, cancel_in = 1'b0;

   logic       wb, sb, db, rfb, rjb;
   logic       wh, sh, dh, rfh, rjh;
   logic [1:0] cb, ch;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vend_ctrl #(.ONE_HOT(1'b0)) dut_i (
      .clk(clk), .rst(rst), .note_in(note_in), .sel_water(sel_water), .sel_snack(sel_snack),
      .sel_drink(sel_drink), .cancel_in(cancel_in), .water_out(wb), .snack_out(sb),
      .drink_out(db), .refund_out(rfb), .reject_out(rjb), .credit_q(cb));

   vend_ctrl #(.ONE_HOT(1'b1)) dut_oh (
      .clk(clk), .rst(rst), .note_in(note_in), .sel_water(sel_water), .sel_snack(sel_snack),
      .sel_drink(sel_drink), .cancel_in(cancel_in), .water_out(wh), .snack_out(sh),
      .drink_out(dh), .refund_out(rfh), .reject_out(rjh), .credit_q(ch));

   // Outputs as {water, snack, drink, refund, reject}.
   task automatic check(input string req, input logic [4:0] exp_o, input int exp_c);
      logic [4:0] ob, oh;
      ob = {wb, sb, db, rfb, rjb};
      oh = {wh, sh, dh, rfh, rjh};
      checks++;
      if (ob !== exp_o || cb !== 2'(exp_c)) begin
         failures++;
         $display("FAIL %s binary: outs=%b credit=%0d expected outs=%b credit=%0d", req, ob, cb, exp_o, exp_c);
      end
      checks++;
      if (oh !== exp_o || ch !== 2'(exp_c)) begin
         failures++;
         $display("FAIL %s onehot: outs=%b credit=%0d expected outs=%b credit=%0d", req, oh, ch, exp_o, exp_c);
      end
   endtask

   // act: 0 idle, 1 note, 2 water, 3 snack, 4 drink, 5 cancel
   task automatic drive(input int act);
      @(negedge clk);
      note_in   = (act == 1);
      sel_water = (act == 2);
      sel_snack = (act == 3);
      sel_drink = (act == 4);
      cancel_in = (act == 5);
      @(negedge clk);
      note_in = 0; sel_water = 0; sel_snack = 0; sel_drink = 0; cancel_in = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R1", 5'b0, 0);
      rst = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      check("R1", 5'b0, 0);
      rst = 1'b0;

      for (int start = 0; start <= 3; start++) begin
         for (int act = 0; act <= 5; act++) begin
            logic [4:0] eo;
            int ec;
            string tag;
            do_reset();
            for (int n = 0; n < start; n++) begin
               drive(1);
               check("R2", 5'b0, n + 1);
            end
            eo = 5'b0;
            ec = start;
            case (act)
               0: tag = "R9";
               1: begin
                  if (start < 3) begin tag = "R2"; ec = start + 1; end
                  else begin tag = "R3"; eo = 5'b00001; end
               end
               2: if (start >= 2) begin tag = "R4"; eo = 5'b10000; ec = start - 2; end
                  else tag = "R7";
               3: if (start >= 2) begin tag = "R5"; eo = 5'b01000; ec = start - 2; end
                  else tag = "R7";
               4: if (start >= 3) begin tag = "R6"; eo = 5'b00100; ec = 0; end
                  else tag = "R7";
               default: begin
                  tag = "R8";
                  if (start > 0) begin eo = 5'b00010; ec = 0; end
               end
            endcase
            drive(act);
            check(tag, eo, ec);
            drive(0);
            check("R10", 5'b0, ec);
         end
      end

      // R1: asynchronous clear mid-cycle with credit held
      do_reset();
      drive(1);
      drive(1);
      check("R2", 5'b0, 2);
      #2;
      rst = 1'b1;
      #1;
      check("R1", 5'b0, 0);
      @(negedge clk);
      rst = 1'b0;

      // R3 then R8: reject leaves full credit that cancel refunds
      drive(1); drive(1); drive(1); drive(1);
      check("R3", 5'b00001, 3);
      drive(5);
      check("R8", 5'b00010, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule